// File: doc/BRIEF.md
# Dual Reference Loss-of-Activity Monitor

This block watches a set of incoming reference clocks (two by default) and gives each one its own loss flag. The flag for a reference rises when that reference has made no transition while a run of feedback-clock edges went by. The feedback clock comes from a local loop and sets the time base. The block also contains the multiplexer that forwards one of the references downstream, chosen by a select input.

All logic runs on a sampling clock that is at least four times faster than any monitored clock. The references and the feedback signal each pass through a two-flop synchronizer. An edge is any change of the synchronized value, so rising and falling transitions count alike. A per-reference counter tallies feedback edges that go by with no reference edge. It saturates at the limit, which is three by default, and the flag is high while the counter sits at the limit. A reference that toggles many times in one interval is healthy: only silence is flagged. The flags are status only and never change the multiplexer.

Top module: `refloss_monitor`

## Requirements
- R1: Each reference has its own counter and flag; edges on one reference never clear or set the flag of another (bit k of `lost_o` belongs to `ref_i[k]`).
- R2: Rising and falling transitions both count as edges, on the feedback input and on every reference input.
- R3: A flag goes high after the third feedback edge that arrives with no edge on its reference in between, and stays low after only one or two such edges.
- R4: Any reference edge returns that reference's count to zero and drops its flag; when a reference edge and a feedback edge are detected in the same sampling cycle, the reference edge wins.
- R5: The count saturates at three, so a flag stays high for as long as its reference stays idle, however many more feedback edges arrive.
- R6: Synchronous reset (`rst` high) clears all counts and flags; after reset the flags stay low until three feedback edges have passed.
- R7: `ref_sel_o` follows `ref_i[0]` when `sel_i` is 0 and `ref_i[1]` when `sel_i` is 1.
- R8: `ref_sel_o` depends only on `sel_i` and the reference inputs; a raised flag never changes the selection.
- R9: Several reference edges within one feedback interval are not an error; the flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, at least 4x faster than the monitored clocks |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | NREF | Reference clock inputs, one bit per reference |
| fb_i | input | 1 | Feedback clock that times the no-activity window |
| sel_i | input | SEL_W | Index of the reference forwarded on `ref_sel_o` |
| lost_o | output | NREF | Loss-of-reference flags, one per reference |
| ref_sel_o | output | 1 | Selected reference |

## Verification
A table of mixed toggle steps drives the feedback alone, each reference alone, both references together, and a reference together with the feedback. These steps separate a count that reaches the limit from one that stops one short, a saturated count from one that wraps, and a shared counter from independent ones. Directed tests then toggle one reference several times between feedback edges, to tell a check for presence apart from one that counts how many edges arrived. They also reset in the middle of a saturated run, and flip the select while a flag is raised, to show that the flags have no path into the multiplexer.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  // number of feedback edges without reference activity that raise a flag
  parameter int unsigned MISS_LIMIT_DEF = 3;
  parameter int unsigned SYNC_STAGES_DEF = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/refmon_edge_sync.sv
module refmon_edge_sync #(
  parameter int unsigned STAGES = refmon_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  // either polarity of transition is an edge
  assign edge_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/refmon_miss_counter.sv
module refmon_miss_counter #(
  parameter int unsigned LIMIT = refmon_pkg::MISS_LIMIT_DEF,
  localparam int unsigned CW   = refmon_pkg::cnt_width(LIMIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_edge,
  input  logic fb_edge,
  output logic lost_o
);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ref_edge) begin
      cnt_q <= '0;                  // activity seen: window restarts
    end else if (fb_edge && (cnt_q != CAP)) begin
      cnt_q <= cnt_q + 1'b1;        // saturating
    end
  end

  assign lost_o = (cnt_q == CAP);
endmodule

// File: rtl/refmon_ref_mux.sv
module refmon_ref_mux #(
  parameter int unsigned NREF  = 2,
  localparam int unsigned SEL_W = (NREF < 2) ? 1 : $clog2(NREF)
) (
  input  logic [NREF-1:0]  ref_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ref_o
);
  always_comb begin
    ref_o = 1'b0;
    for (int i = 0; i < NREF; i++) begin
      if (sel_i == SEL_W'(i)) ref_o = ref_i[i];
    end
  end
endmodule

// File: rtl/refloss_monitor.sv
module refloss_monitor #(
  parameter int unsigned NREF        = 2,
  parameter int unsigned SYNC_STAGES = refmon_pkg::SYNC_STAGES_DEF,
  parameter int unsigned MISS_LIMIT  = refmon_pkg::MISS_LIMIT_DEF,
  localparam int unsigned SEL_W      = (NREF < 2) ? 1 : $clog2(NREF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREF-1:0]  ref_i,
  input  logic             fb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NREF-1:0]  lost_o,
  output logic             ref_sel_o
);
  logic            fb_edge;
  logic [NREF-1:0] ref_edge;

  refmon_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk(clk), .rst(rst), .din(fb_i), .edge_o(fb_edge)
  );

  for (genvar k = 0; k < NREF; k++) begin : g_chan
    refmon_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst(rst), .din(ref_i[k]), .edge_o(ref_edge[k])
    );
    refmon_miss_counter #(.LIMIT(MISS_LIMIT)) u_cnt (
      .clk(clk), .rst(rst), .ref_edge(ref_edge[k]), .fb_edge(fb_edge),
      .lost_o(lost_o[k])
    );
  end

  refmon_ref_mux #(.NREF(NREF)) u_mux (
    .ref_i(ref_i), .sel_i(sel_i), .ref_o(ref_sel_o)
  );
endmodule

// File: rtl/refloss_monitor_chk.sv
module refloss_monitor_chk #(
  parameter int unsigned NREF  = 2,
  parameter int unsigned SEL_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [NREF-1:0]  ref_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [NREF-1:0]  lost_o,
  input logic             ref_sel_o,
  input logic             fb_edge,
  input logic [NREF-1:0]  ref_edge
);
  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> (lost_o == '0));

  assert_mux_only_inputs_R8: assert property (@(posedge clk) disable iff (rst)
    ($stable(sel_i) && $stable(ref_i)) |-> $stable(ref_sel_o));

  for (genvar k = 0; k < NREF; k++) begin : g_k
    assert_rise_needs_fb_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(lost_o[k]) |-> $past(fb_edge));

    assert_ref_edge_clears_R4: assert property (@(posedge clk) disable iff (rst)
      ref_edge[k] |=> !lost_o[k]);

    assert_idle_holds_flag_R5: assert property (@(posedge clk) disable iff (rst)
      (lost_o[k] && !ref_edge[k]) |=> lost_o[k]);
  end
endmodule

bind refloss_monitor refloss_monitor_chk #(.NREF(NREF), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .ref_i(ref_i), .sel_i(sel_i), .lost_o(lost_o),
  .ref_sel_o(ref_sel_o), .fb_edge(fb_edge), .ref_edge(ref_edge)
);

// File: tb/test_refloss_monitor.sv
module test_refloss_monitor;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] ref_i;
  logic       fb_i;
  logic [0:0] sel_i;
  logic [1:0] lost_o;
  logic       ref_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  refloss_monitor i_refloss_monitor (
    .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i), .sel_i(sel_i),
    .lost_o(lost_o), .ref_sel_o(ref_sel_o)
  );

  // {toggle fb, toggle ref1, toggle ref0, expected lost[1:0]}
  localparam logic [4:0] VEC [14] = '{
    5'b100_00, 5'b100_00, 5'b100_11, 5'b100_11,
    5'b001_10, 5'b100_10, 5'b101_10, 5'b010_00,
    5'b100_00, 5'b100_00, 5'b010_00, 5'b100_01,
    5'b100_01, 5'b100_11
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] mask);
    @(negedge clk);
    fb_i  ^= mask[2];
    ref_i ^= mask[1:0];
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fb_i = 1'b0; ref_i = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; fb_i = 1'b0; ref_i = 2'b00; sel_i = 1'b0;
    do_reset();
    check("R6 reset state", lost_o, 2'b00);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][4:2]);
      check($sformatf("R1/R2/R3/R4/R5 vec %0d", i), lost_o, VEC[i][1:0]);
    end

    // R6: reset in the middle of a saturated run
    step(3'b100); step(3'b100);
    check("R5 saturated before reset", lost_o, 2'b11);
    do_reset();
    check("R6 cleared by reset", lost_o, 2'b00);
    step(3'b100); step(3'b100);
    check("R6 low after two feedback edges", lost_o, 2'b00);
    step(3'b100);
    check("R6 R3 high after third edge", lost_o, 2'b11);

    // R9: many ref0 edges within one feedback interval
    do_reset();
    step(3'b100); step(3'b100);
    for (int j = 0; j < 4; j++) step(3'b001);
    step(3'b100);
    check("R9 busy ref0 not flagged", lost_o, 2'b10);

    // R7: selection of each reference
    do_reset();
    @(negedge clk); ref_i = 2'b01; sel_i = 1'b0;
    @(negedge clk); check("R7 sel0 picks ref0", {1'b0, ref_sel_o}, 2'b01);
    sel_i = 1'b1;
    @(negedge clk); check("R7 sel1 picks ref1", {1'b0, ref_sel_o}, 2'b00);
    ref_i = 2'b10;
    @(negedge clk); check("R7 sel1 follows ref1", {1'b0, ref_sel_o}, 2'b01);

    // R8: flags raised, selection unchanged
    step(3'b100); step(3'b100); step(3'b100);
    check("R8 flags raised", lost_o, 2'b11);
    check("R8 sel1 still ref1", {1'b0, ref_sel_o}, 2'b01);
    sel_i = 1'b0;
    @(negedge clk); check("R8 sel0 still ref0", {1'b0, ref_sel_o}, 2'b00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule